// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block sits between the pins of a parallel NOR-style flash device and its internals. Each clock it samples the active-low chip-enable, output-enable, write-enable and hardware-reset pins and turns them into exactly one bus operation: read, write, standby, output disable or reset. For reads it drives the 16-bit data bus with per-lane output enables. For writes it captures the address and data into a command register that a downstream command state machine would consume.

The data bus works in one of two configurations, chosen by a word-select pin. In word configuration all sixteen lanes carry data. In byte configuration only the low eight lanes carry data, lanes 8 to 14 stay at high impedance, and data pin 15 becomes an extra least-significant address input that picks one byte of the addressed word. The array behind the bus is a synchronous model whose depth is set by a parameter; the full-size device would use 19 word-address bits. Its contents are a computed fill pattern that is loaded at reset. A separate mode flag starts in array-read and drops as soon as a command has been latched. Until a hardware reset, reads then return the latched command data, which stands in for whatever the state machine would present.

Top module: `flash_bus_front`

## Requirements
- R1: After the synchronous reset input `rst_n` is released, all output enables are 0, `array_mode` is 1 and `cmd_valid` is 0.
- R2: With `pin_reset_n` high and `pin_ce_n` high, every data lane is at high impedance (`dq_oe` = 0) one clock later, whatever `pin_oe_n` and `pin_we_n` are.
- R3: With `pin_reset_n` low, `dq_oe` is 0 one clock later, `array_mode` returns to 1, and a write that was in progress is dropped without a `cmd_valid` pulse.
- R4: A word read (reset high, `pin_ce_n` low, `pin_oe_n` low, `pin_we_n` high, `pin_word` high) in array mode gives `dq_oe` = 16'hFFFF and `dq_out` = array word at `addr` one clock later. Array word a holds the low 16 bits of (a × 16'h9E37), exclusive-ORed with 16'hA55A.
- R5: A byte read (same controls, `pin_word` low) gives `dq_oe` = 16'h00FF. `dq_out[7:0]` holds the low byte of the source word when `dq_in[15]` = 0 and the high byte when `dq_in[15]` = 1.
- R6: Chip-enable low with output-enable high and write-enable high is output disable (`dq_oe` = 0). Chip-enable low with both output-enable and write-enable low is also treated as output disable and latches nothing.
- R7: A write (reset high, `pin_ce_n` low, `pin_we_n` low, `pin_oe_n` high) captures `addr` every cycle it lasts. In word mode it captures all 16 data bits; in byte mode it captures `dq_in[7:0]` with the upper byte zero, `cmd_am1` = `dq_in[15]` and `cmd_byte` = 1. On the clock edge after the first non-write, non-reset cycle, `cmd_valid` is 1 for exactly one clock.
- R8: `array_mode` drops to 0 in the same cycle `cmd_valid` rises. From then on, reads return `cmd_data`, with byte steering applied as in R5, until a hardware reset restores array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| pin_ce_n | input | 1 | Chip enable, active low |
| pin_oe_n | input | 1 | Output enable, active low |
| pin_we_n | input | 1 | Write enable, active low |
| pin_reset_n | input | 1 | Hardware reset pin, active low |
| pin_word | input | 1 | 1 = word configuration, 0 = byte configuration |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus as seen at the pins; bit 15 is the byte-select address in byte mode |
| dq_out | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-lane output enable (0 = high impedance) |
| cmd_addr | output | ADDR_W | Latched command word address |
| cmd_am1 | output | 1 | Latched byte-select bit of the command |
| cmd_byte | output | 1 | Command was written in byte configuration |
| cmd_data | output | 16 | Latched command data |
| cmd_valid | output | 1 | One-clock strobe: a new command is latched |
| array_mode | output | 1 | 1 while reads return array data |

## Verification
The interesting collision is a read issued in the very cycle after a write pulse ends. The command strobe and the drop of array mode then land on the same edge that registers the read data. The bench provokes this directly and expects the read to return the freshly latched command word, not the array word. It also runs the mirror case, a hardware reset placed right after a write, and expects no strobe and array mode kept. Each case is judged against a reference model in the bench. That model applies the state update before forming the expected bus value.

// File: rtl/flash_bus_pkg.sv
// Shared types and helpers for the flash bus front end.
// Assumes a 16-bit data bus split into two 8-bit lanes groups.
package flash_bus_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = 8;

    // One decoded bus operation per clock.
    typedef enum logic [2:0] {
        BOP_RESET   = 3'd0,
        BOP_STANDBY = 3'd1,
        BOP_READ    = 3'd2,
        BOP_WRITE   = 3'd3,
        BOP_OUTDIS  = 3'd4
    } bus_op_e;

    // Fill value of array word a: low 16 bits of a*0x9E37, xor 0xA55A.
    function automatic logic [DQ_W-1:0] fill_word(input logic [31:0] a);
        logic [31:0] prod;
        prod = a * 32'h0000_9E37;
        return prod[DQ_W-1:0] ^ 16'hA55A;
    endfunction

endpackage

// File: rtl/flash_op_decode.sv
// Turns the four active-low control pins into one bus operation.
// Priority: hardware reset, then chip-enable, then write, then read.
// Output-enable and write-enable both low is folded into output disable.
module flash_op_decode
    import flash_bus_pkg::*;
(
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    hw_rst_n,
    output bus_op_e op
);

    // Priority decode of the pin levels.
    always_comb begin
        if (!hw_rst_n)            op = BOP_RESET;
        else if (ce_n)            op = BOP_STANDBY;
        else if (!we_n && oe_n)   op = BOP_WRITE;
        else if (!oe_n && we_n)   op = BOP_READ;
        else                      op = BOP_OUTDIS;
    end

endmodule

// File: rtl/flash_array_model.sv
// Synchronous array model: one registered read per clock.
// Contents are the package fill pattern, loaded during synchronous reset.
// Assumes DEPTH stays small enough to hold in registers.
module flash_array_model
    import flash_bus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DQ_W-1:0]   rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DQ_W-1:0] mem [DEPTH];

    // Load the fill pattern on reset, otherwise register the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= fill_word(32'(i));
            end
            rd_word <= '0;
        end else begin
            rd_word <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/flash_cmd_latch.sv
// Command register: captures address and data during a write,
// strobes cmd_valid once the write ends, and tracks the read mode flag.
// Assumes the op input is already priority-decoded.
module flash_cmd_latch
    import flash_bus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_am1,
    output logic              cmd_byte,
    output logic [DQ_W-1:0]   cmd_data,
    output logic              cmd_valid,
    output logic              array_mode
);

    logic wr_prev;
    logic wr_end;

    // The write pulse has ended cleanly (not cut short by hardware reset).
    always_comb wr_end = wr_prev && (op != BOP_WRITE) && (op != BOP_RESET);

    // Follow the bus while writing; remember whether the last cycle was a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_am1  <= 1'b0;
            cmd_byte <= 1'b0;
            cmd_data <= '0;
            wr_prev  <= 1'b0;
        end else begin
            wr_prev <= (op == BOP_WRITE);
            if (op == BOP_WRITE) begin
                cmd_addr <= addr;
                cmd_byte <= byte_mode;
                cmd_am1  <= byte_mode & dq_in[DQ_W-1];
                cmd_data <= byte_mode ? {{(DQ_W-BYTE_W){1'b0}}, dq_in[BYTE_W-1:0]}
                                      : dq_in;
            end
        end
    end

    // One-clock strobe and mode flag for the downstream state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            array_mode <= 1'b1;
        end else begin
            cmd_valid <= wr_end;
            if (op == BOP_RESET) array_mode <= 1'b1;
            else if (wr_end)     array_mode <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_dq_steer.sv
// Steers the read source onto the data lanes and sets per-lane enables.
// Byte mode: only the low lanes drive, the byte is picked by the A-1 bit.
module flash_dq_steer
    import flash_bus_pkg::*;
(
    input  bus_op_e         op_q,
    input  logic            byte_q,
    input  logic            am1_q,
    input  logic            array_mode,
    input  logic [DQ_W-1:0] arr_word,
    input  logic [DQ_W-1:0] cmd_word,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe
);

    logic            drive;
    logic [DQ_W-1:0] src;

    // Pick the read source and shape it for the bus width.
    always_comb begin
        drive = (op_q == BOP_READ);
        src   = array_mode ? arr_word : cmd_word;
        if (!drive)
            dq_out = '0;
        else if (byte_q)
            dq_out = {{(DQ_W-BYTE_W){1'b0}},
                      am1_q ? src[DQ_W-1:BYTE_W] : src[BYTE_W-1:0]};
        else
            dq_out = src;
    end

    // Per-lane enable: low lanes follow drive, upper lanes only in word mode.
    for (genvar g = 0; g < DQ_W; g++) begin : g_lane
        if (g < BYTE_W) begin : g_low
            assign dq_oe[g] = drive;
        end else begin : g_high
            assign dq_oe[g] = drive & ~byte_q;
        end
    end

endmodule

// File: rtl/flash_bus_front.sv
// Top of the flash bus front end: decodes pins each clock, registers the
// operation, reads the array and drives the data lanes one clock later.
// Assumes pins are already synchronous to clk.
module flash_bus_front
    import flash_bus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_ce_n,
    input  logic              pin_oe_n,
    input  logic              pin_we_n,
    input  logic              pin_reset_n,
    input  logic              pin_word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_am1,
    output logic              cmd_byte,
    output logic [15:0]       cmd_data,
    output logic              cmd_valid,
    output logic              array_mode
);

    bus_op_e         op;
    bus_op_e         op_q;
    logic            byte_q;
    logic            am1_q;
    logic [DQ_W-1:0] arr_word;

    flash_op_decode u_dec (
        .ce_n     (pin_ce_n),
        .oe_n     (pin_oe_n),
        .we_n     (pin_we_n),
        .hw_rst_n (pin_reset_n),
        .op       (op)
    );

    flash_array_model #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr),
        .rd_word (arr_word)
    );

    flash_cmd_latch #(.ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .byte_mode  (~pin_word),
        .addr       (addr),
        .dq_in      (dq_in),
        .cmd_addr   (cmd_addr),
        .cmd_am1    (cmd_am1),
        .cmd_byte   (cmd_byte),
        .cmd_data   (cmd_data),
        .cmd_valid  (cmd_valid),
        .array_mode (array_mode)
    );

    // Register the operation and bus shape alongside the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= BOP_STANDBY;
            byte_q <= 1'b0;
            am1_q  <= 1'b0;
        end else begin
            op_q   <= op;
            byte_q <= ~pin_word;
            am1_q  <= dq_in[DQ_W-1];
        end
    end

    flash_dq_steer u_steer (
        .op_q       (op_q),
        .byte_q     (byte_q),
        .am1_q      (am1_q),
        .array_mode (array_mode),
        .arr_word   (arr_word),
        .cmd_word   (cmd_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

endmodule

// File: rtl/flash_bus_front_chk.sv
// Checker for flash_bus_front: relates pin levels to the lane enables
// and command strobe one clock later. Bound to every instance.
module flash_bus_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pin_ce_n,
    input logic        pin_oe_n,
    input logic        pin_we_n,
    input logic        pin_reset_n,
    input logic        pin_word,
    input logic [15:0] dq_oe,
    input logic        cmd_valid,
    input logic        array_mode
);

    logic rd_pins;
    always_comb rd_pins = pin_reset_n && !pin_ce_n && !pin_oe_n && pin_we_n;

    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_reset_n && pin_ce_n) |=> (dq_oe == 16'h0000));

    assert_hw_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_reset_n |=> (dq_oe == 16'h0000 && array_mode && !cmd_valid));

    assert_word_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pins && pin_word) |=> (dq_oe == 16'hFFFF));

    assert_byte_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pins && !pin_word) |=> (dq_oe == 16'h00FF));

    assert_out_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_reset_n && !pin_ce_n && pin_oe_n && pin_we_n) |=> (dq_oe == 16'h0000));

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_mode_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !array_mode);

endmodule

bind flash_bus_front flash_bus_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_ce_n    (pin_ce_n),
    .pin_oe_n    (pin_oe_n),
    .pin_we_n    (pin_we_n),
    .pin_reset_n (pin_reset_n),
    .pin_word    (pin_word),
    .dq_oe       (dq_oe),
    .cmd_valid   (cmd_valid),
    .array_mode  (array_mode)
);

// File: tb/test_flash_bus_front.sv
// Scoreboard bench: the driver task applies pins and queues the expected
// bus state; the monitor compares it one clock later, after the edge.
module test_flash_bus_front;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hrst_n = 1'b1, word = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dq_out, dq_oe, cmd_data;
    logic [AW-1:0] cmd_addr;
    logic          cmd_am1, cmd_byte, cmd_valid, array_mode;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    flash_bus_front #(.ADDR_W(AW)) i_flash_bus_front (
        .clk(clk), .rst_n(rst_n), .pin_ce_n(ce_n), .pin_oe_n(oe_n), .pin_we_n(we_n),
        .pin_reset_n(hrst_n), .pin_word(word), .addr(addr), .dq_in(din),
        .dq_out(dq_out), .dq_oe(dq_oe), .cmd_addr(cmd_addr), .cmd_am1(cmd_am1),
        .cmd_byte(cmd_byte), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
        .array_mode(array_mode)
    );

    typedef struct {
        logic [15:0]   oe;
        logic [15:0]   dout;
        logic          cv;
        logic          am;
        logic [15:0]   cdata;
        logic [AW-1:0] caddr;
        logic          cam1;
        logic          cbyte;
        string         req;
    } exp_t;

    exp_t sb[$];

    // Bench reference model state
    logic          m_am = 1'b1, m_wrp = 1'b0, m_am1 = 1'b0, m_byte = 1'b0;
    logic [15:0]   m_data = '0;
    logic [AW-1:0] m_addr = '0;

    function automatic logic [15:0] pat(input int a);
        int unsigned p;
        p = a * 40503;
        return p[15:0] ^ 16'hA55A;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: apply pins at the falling edge and queue the expected result.
    task automatic step(input logic ce, input logic oe, input logic we, input logic hr,
                        input logic wd, input logic [AW-1:0] a, input logic [15:0] d,
                        input string req);
        exp_t e;
        int   op;  // 0 reset 1 standby 2 read 3 write 4 disable
        logic strobe;
        logic [15:0] src;
        @(negedge clk);
        ce_n = ce; oe_n = oe; we_n = we; hrst_n = hr; word = wd; addr = a; din = d;
        if (!hr) op = 0;
        else if (ce) op = 1;
        else if (!we && oe) op = 3;
        else if (!oe && we) op = 2;
        else op = 4;
        strobe = m_wrp && op != 3 && op != 0;
        if (op == 0) m_am = 1'b1;
        else if (strobe) m_am = 1'b0;
        if (op == 3) begin
            m_addr = a; m_byte = !wd; m_am1 = !wd && d[15];
            m_data = wd ? d : {8'h00, d[7:0]};
        end
        m_wrp = (op == 3);
        src = m_am ? pat(int'(a)) : m_data;
        e.oe = 16'h0000; e.dout = 16'h0000;
        if (op == 2) begin
            if (wd) begin e.oe = 16'hFFFF; e.dout = src; end
            else begin e.oe = 16'h00FF; e.dout = {8'h00, d[15] ? src[15:8] : src[7:0]}; end
        end
        e.cv = strobe; e.am = m_am; e.cdata = m_data; e.caddr = m_addr;
        e.cam1 = m_am1; e.cbyte = m_byte; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare just after the rising edge that registered the step.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "dq_oe", 32'(dq_oe), 32'(e.oe));
                check(e.req, "dq_out", 32'(dq_out & dq_oe), 32'(e.dout));
                check(e.req, "cmd_valid", 32'(cmd_valid), 32'(e.cv));
                check(e.req, "array_mode", 32'(array_mode), 32'(e.am));
                if (e.cv) begin
                    check(e.req, "cmd_data", 32'(cmd_data), 32'(e.cdata));
                    check(e.req, "cmd_addr", 32'(cmd_addr), 32'(e.caddr));
                    check(e.req, "cmd_am1", 32'(cmd_am1), 32'(e.cam1));
                    check(e.req, "cmd_byte", 32'(cmd_byte), 32'(e.cbyte));
                end
            end
        end
    end

    bit done = 1'b0;

    initial begin
        #400000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "dq_oe", 32'(dq_oe), 32'h0);
        check("R1", "array_mode", 32'(array_mode), 32'h1);
        check("R1", "cmd_valid", 32'(cmd_valid), 32'h0);
        // R4: word reads in array mode
        step(0, 0, 1, 1, 1, 8'd0,   16'h0000, "R4");
        step(0, 0, 1, 1, 1, 8'd5,   16'h0000, "R4");
        step(0, 0, 1, 1, 1, 8'd255, 16'h0000, "R4");
        for (int i = 16; i < 32; i++) step(0, 0, 1, 1, 1, AW'(i * 7), 16'h0000, "R4");
        // R5: byte reads, low and high byte
        step(0, 0, 1, 1, 0, 8'd5, 16'h0000, "R5");
        step(0, 0, 1, 1, 0, 8'd5, 16'h8000, "R5");
        step(0, 0, 1, 1, 0, 8'd77, 16'hFFFF, "R5");
        // R2: standby with various other pins
        step(1, 0, 1, 1, 1, 8'd9, 16'h0000, "R2");
        step(1, 1, 0, 1, 1, 8'd9, 16'h1234, "R2");
        step(1, 0, 0, 1, 0, 8'd9, 16'h1234, "R2");
        // R6: output disable and conflicting strobes
        step(0, 1, 1, 1, 1, 8'd9, 16'h0000, "R6");
        step(0, 0, 0, 1, 1, 8'd9, 16'h5555, "R6");
        step(1, 1, 1, 1, 1, 8'd9, 16'h0000, "R6");
        // R3: hardware reset with read controls
        step(0, 0, 1, 0, 1, 8'd9, 16'h0000, "R3");
        step(0, 0, 1, 0, 0, 8'd9, 16'h8000, "R3");
        // R7: word write then standby
        step(0, 1, 0, 1, 1, 8'h12, 16'hBEEF, "R7");
        step(0, 1, 0, 1, 1, 8'h12, 16'hBEEF, "R7");
        step(1, 1, 1, 1, 1, 8'h00, 16'h0000, "R7");
        step(1, 1, 1, 1, 1, 8'h00, 16'h0000, "R7");
        // R8: reads now echo the command data
        step(0, 0, 1, 1, 1, 8'd3, 16'h0000, "R8");
        step(0, 0, 1, 1, 0, 8'd3, 16'h8000, "R8");
        step(0, 0, 1, 1, 0, 8'd3, 16'h0000, "R8");
        // R3/R8: hardware reset restores array reads
        step(1, 1, 1, 0, 1, 8'd3, 16'h0000, "R3");
        step(0, 0, 1, 1, 1, 8'd3, 16'h0000, "R8");
        // R7: byte write with A-1 set
        step(0, 1, 0, 1, 0, 8'h21, 16'h8077, "R7");
        step(1, 1, 1, 1, 1, 8'h00, 16'h0000, "R7");
        step(0, 0, 1, 1, 0, 8'h40, 16'h0000, "R8");
        // R3: write cut by hardware reset gives no strobe
        step(1, 1, 1, 0, 1, 8'h00, 16'h0000, "R3");
        step(0, 1, 0, 1, 1, 8'h33, 16'hCAFE, "R3");
        step(0, 1, 1, 0, 1, 8'h33, 16'h0000, "R3");
        step(0, 0, 1, 1, 1, 8'h33, 16'h0000, "R3");
        // R8: read in the cycle right after the write ends
        step(0, 1, 0, 1, 1, 8'h44, 16'h600D, "R8");
        step(0, 0, 1, 1, 1, 8'h44, 16'h0000, "R8");
        step(0, 0, 1, 1, 0, 8'h44, 16'h8000, "R8");
        step(1, 1, 1, 1, 1, 8'h00, 16'h0000, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule